// File: doc/BRIEF.md
# Conversion Result Window Comparator

This block watches the stream of finished converter results and tests each one against a lower and an upper threshold. A result-valid strobe qualifies the result word. The thresholds, a window mode, a signed/unsigned select and a resolution select (8, 10 or 12 bits) are static configuration values taken straight from ports. When a qualified result meets the selected window condition, a sticky status flag is set and, if enabled, a single-cycle event pulse is produced.

The comparison width follows the resolution. Bits of the result and of both thresholds above the selected width are discarded. In signed mode, the top bit of the selected width acts as the sign bit. An 8-bit signed compare therefore reads bit 7 as the sign even when bit 8 is clear. The status flag stays set until software writes a one to the clear input. A new match in the same cycle as a clear wins over the clear.

Top module: `win_result_monitor`

## Requirements
- R1: With `signed_en`=0, the low n bits of the result and of each threshold are compared as unsigned numbers, where n is the selected resolution.
- R2: With `signed_en`=1, the low n bits are compared as two's-complement numbers whose sign is bit n-1, whatever the bits above it hold.
- R3: `res_sel` encodes the resolution: 0 is 8 bits, 1 is 10 bits, 2 and 3 are 12 bits. Result and threshold bits at position n and above never affect the outcome.
- R4: `win_mode` encodes the window condition: 0 off, 1 result > lower, 2 result < upper, 3 lower < result < upper, 4 result < lower or result > upper. All inequalities are strict.
- R5: A qualified result (`res_valid`=1) that meets the condition sets `win_flag` at that clock edge, so the flag is visible in the following cycle.
- R6: Mode 0 and the unused codes 5 to 7 never set `win_flag` and never pulse `win_evt`. Cycles with `res_valid`=0 never set the flag or pulse the event.
- R7: `win_evt` is high for exactly the cycle after each matching qualified result, and only when `evt_en` was 1 with that result.
- R8: `win_flag` stays set until `flag_clr`=1 at a clock edge clears it. When a clear and a match occur at the same edge, the flag stays set.
- R9: While `rst_n` is low, `win_flag` and `win_evt` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | Qualifies `res_data` for one cycle |
| res_data | input | DATA_W | Conversion result word |
| thr_lower | input | DATA_W | Lower threshold |
| thr_upper | input | DATA_W | Upper threshold |
| win_mode | input | 3 | Window condition select |
| signed_en | input | 1 | 1 selects a two's-complement compare |
| res_sel | input | 2 | Resolution select |
| evt_en | input | 1 | Enables the event pulse |
| flag_clr | input | 1 | Write-one clear for the status flag |
| win_flag | output | 1 | Sticky window status |
| win_evt | output | 1 | One-cycle window event |

## Verification
A wrong sign position or a wrong width mask changes the match decision for results near the thresholds or with high bits set. This appears on `win_flag` and `win_evt` in the cycle right after the qualified result. A flag register that drops early or fails to set shows up as a flag mismatch in the very next cycle, because the bench tracks the flag every cycle. An event pulse that is stretched or unmasked is caught in the cycle after a non-matching or unenabled result.

// File: rtl/win_cmp_pkg.sv
package win_cmp_pkg;

  localparam logic [2:0] WM_OFF     = 3'd0;
  localparam logic [2:0] WM_ABOVE   = 3'd1;
  localparam logic [2:0] WM_BELOW   = 3'd2;
  localparam logic [2:0] WM_INSIDE  = 3'd3;
  localparam logic [2:0] WM_OUTSIDE = 3'd4;

  typedef enum logic [1:0] {
    RES_W8  = 2'd0,
    RES_W10 = 2'd1,
    RES_W12 = 2'd2,
    RES_W12X = 2'd3
  } res_sel_e;

  localparam int unsigned MAX_RES_BITS = 12;

  // Number of significant bits for a resolution code.
  function automatic int unsigned res_bits(input logic [1:0] sel);
    case (sel)
      RES_W8:  return 8;
      RES_W10: return 10;
      default: return 12;
    endcase
  endfunction

endpackage

// File: rtl/win_align.sv
module win_align #(
  parameter int DATA_W = 16,
  localparam int EXT_W = DATA_W + 1
) (
  input  logic [DATA_W-1:0] raw,
  input  logic [1:0]        res_sel,
  input  logic              signed_en,
  output logic [EXT_W-1:0]  aligned
);
  import win_cmp_pkg::*;

  // Keep the low n bits; fill the rest with the sign (bit n-1) or with zero.
  function automatic logic [EXT_W-1:0] widen(input logic [DATA_W-1:0] v,
                                             input int unsigned n,
                                             input logic sgn);
    logic [EXT_W-1:0] o;
    logic fill;
    fill = sgn & v[n-1];
    for (int i = 0; i < EXT_W; i++) begin
      if (i < int'(n)) o[i] = v[i];
      else             o[i] = fill;
    end
    return o;
  endfunction

  always_comb aligned = widen(raw, res_bits(res_sel), signed_en);

endmodule

// File: rtl/win_decide.sv
module win_decide #(
  parameter int DATA_W = 16,
  localparam int EXT_W = DATA_W + 1
) (
  input  logic [EXT_W-1:0] val,
  input  logic [EXT_W-1:0] lo,
  input  logic [EXT_W-1:0] hi,
  input  logic [2:0]       mode,
  output logic             above_lo,
  output logic             below_hi,
  output logic             cond
);
  import win_cmp_pkg::*;

  // Operands are already sign- or zero-extended by one bit, so a signed
  // compare is correct for both modes.
  function automatic logic gt(input logic [EXT_W-1:0] a, input logic [EXT_W-1:0] b);
    return $signed(a) > $signed(b);
  endfunction

  function automatic logic pick(input logic [2:0] m, input logic a_lo,
                                input logic b_hi, input logic lo_gt_v,
                                input logic v_gt_hi);
    case (m)
      WM_ABOVE:   return a_lo;
      WM_BELOW:   return b_hi;
      WM_INSIDE:  return a_lo & b_hi;
      WM_OUTSIDE: return lo_gt_v | v_gt_hi;
      default:    return 1'b0;
    endcase
  endfunction

  logic lo_above_val, val_above_hi;

  always_comb begin
    above_lo     = gt(val, lo);
    below_hi     = gt(hi, val);
    lo_above_val = gt(lo, val);
    val_above_hi = gt(val, hi);
    cond         = pick(mode, above_lo, below_hi, lo_above_val, val_above_hi);
  end

endmodule

// File: rtl/win_status.sv
module win_status (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic evt_en,
  input  logic clr,
  output logic flag,
  output logic evt
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= 1'b0;
      evt  <= 1'b0;
    end else begin
      if (hit)      flag <= 1'b1;
      else if (clr) flag <= 1'b0;
      evt <= hit & evt_en;
    end
  end

endmodule

// File: rtl/win_result_monitor.sv
module win_result_monitor #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_data,
  input  logic [DATA_W-1:0] thr_lower,
  input  logic [DATA_W-1:0] thr_upper,
  input  logic [2:0]        win_mode,
  input  logic              signed_en,
  input  logic [1:0]        res_sel,
  input  logic              evt_en,
  input  logic              flag_clr,
  output logic              win_flag,
  output logic              win_evt
);
  localparam int EXT_W = DATA_W + 1;
  localparam int N_OPS = 3;

  logic [DATA_W-1:0] op_raw [N_OPS];
  logic [EXT_W-1:0]  op_ext [N_OPS];
  logic above_lo, below_hi, cond_met, hit_now;

  assign op_raw[0] = res_data;
  assign op_raw[1] = thr_lower;
  assign op_raw[2] = thr_upper;

  for (genvar g = 0; g < N_OPS; g++) begin : g_align
    win_align #(.DATA_W(DATA_W)) u_align (
      .raw       (op_raw[g]),
      .res_sel   (res_sel),
      .signed_en (signed_en),
      .aligned   (op_ext[g])
    );
  end

  win_decide #(.DATA_W(DATA_W)) u_decide (
    .val      (op_ext[0]),
    .lo       (op_ext[1]),
    .hi       (op_ext[2]),
    .mode     (win_mode),
    .above_lo (above_lo),
    .below_hi (below_hi),
    .cond     (cond_met)
  );

  assign hit_now = res_valid & cond_met;

  win_status u_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .hit    (hit_now),
    .evt_en (evt_en),
    .clr    (flag_clr),
    .flag   (win_flag),
    .evt    (win_evt)
  );

endmodule

// File: rtl/win_cmp_checks.sv
module win_cmp_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       res_valid,
  input logic [2:0] win_mode,
  input logic       evt_en,
  input logic       flag_clr,
  input logic       hit_now,
  input logic       above_lo,
  input logic       below_hi,
  input logic       win_flag,
  input logic       win_evt
);

  a_r5_hit_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    hit_now |=> win_flag);

  a_r6_off_mode_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (win_mode == 3'd0 || win_mode > 3'd4) |-> !hit_now);

  a_r6_no_valid_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> !hit_now);

  a_r4_inside_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
    (win_mode == 3'd3 && hit_now) |-> (above_lo && below_hi));

  a_r7_evt_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_now || !evt_en) |=> !win_evt);

  a_r7_evt_follows_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_now && evt_en) |=> win_evt);

  a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !hit_now) |=> !win_flag);

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (win_flag && !flag_clr) |=> win_flag);

endmodule

bind win_result_monitor win_cmp_checks u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .res_valid (res_valid),
  .win_mode  (win_mode),
  .evt_en    (evt_en),
  .flag_clr  (flag_clr),
  .hit_now   (hit_now),
  .above_lo  (above_lo),
  .below_hi  (below_hi),
  .win_flag  (win_flag),
  .win_evt   (win_evt)
);

// File: tb/test_win_result_monitor.sv
module test_win_result_monitor;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic res_valid = 1'b0;
  logic [DW-1:0] res_data = '0, thr_lower = '0, thr_upper = '0;
  logic [2:0] win_mode = '0;
  logic signed_en = 1'b0;
  logic [1:0] res_sel = '0;
  logic evt_en = 1'b0, flag_clr = 1'b0;
  logic win_flag, win_evt;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  bit exp_flag = 0;

  always #2 clk = ~clk;

  win_result_monitor #(.DATA_W(DW)) i_win_result_monitor (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
    .thr_lower(thr_lower), .thr_upper(thr_upper), .win_mode(win_mode),
    .signed_en(signed_en), .res_sel(res_sel), .evt_en(evt_en),
    .flag_clr(flag_clr), .win_flag(win_flag), .win_evt(win_evt));

  // Value of the low n bits as an integer, signed if requested (R1, R2, R3).
  function automatic int as_num(int unsigned raw, int n, bit sgn);
    int m;
    m = int'(raw & ((32'd1 << n) - 1));
    if (sgn && ((m >> (n - 1)) & 1) == 1) m = m - (1 << n);
    return m;
  endfunction

  function automatic int width_of(logic [1:0] s);
    if (s == 2'd0) return 8;
    if (s == 2'd1) return 10;
    return 12;
  endfunction

  function automatic bit ref_hit(bit v, int unsigned d, int unsigned lo,
                                 int unsigned hi, int m, bit sgn, logic [1:0] rs);
    int n, r, l, h;
    if (!v) return 0;
    n = width_of(rs);
    r = as_num(d, n, sgn); l = as_num(lo, n, sgn); h = as_num(hi, n, sgn);
    case (m)
      1: return r > l;
      2: return r < h;
      3: return (r > l) && (r < h);
      4: return (r < l) || (r > h);
      default: return 0;
    endcase
  endfunction

  task automatic check(string tag, logic got, logic want, string what);
    n_cmp++;
    if (got !== want) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, got, want, $time);
    end
  endtask

  // Drive one cycle, then compare with the model after the edge.
  task automatic cycle(bit v, int unsigned d, int unsigned lo, int unsigned hi,
                       int m, bit sgn, logic [1:0] rs, bit en, bit clr, string tag);
    bit h;
    res_valid = v; res_data = d[DW-1:0]; thr_lower = lo[DW-1:0];
    thr_upper = hi[DW-1:0]; win_mode = m[2:0]; signed_en = sgn;
    res_sel = rs; evt_en = en; flag_clr = clr;
    h = ref_hit(v, d, lo, hi, m, sgn, rs);
    exp_flag = h ? 1'b1 : (clr ? 1'b0 : exp_flag);
    @(posedge clk); #1;
    check(tag, win_flag, exp_flag, "flag");
    check(tag, win_evt, h & en, "event");
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check("R9", win_flag, 1'b0, "flag in reset");
    check("R9", win_evt, 1'b0, "event in reset");
    rst_n = 1'b1;

    // R2: bit 7 is the sign at 8 bits, 0x080 is -128, not above lower 0.
    cycle(1, 'h080, 'h000, 'h000, 1, 1, 2'd0, 1, 0, "R2");
    check("R2", win_flag, 1'b0, "signed 8-bit sign");
    // R1: same value unsigned is 128 > 0.
    cycle(1, 'h080, 'h000, 'h000, 1, 0, 2'd0, 1, 0, "R1");
    check("R1", win_flag, 1'b1, "unsigned 8-bit");
    // R8: clear and new match together keep the flag.
    cycle(1, 'h080, 'h000, 'h000, 1, 0, 2'd0, 0, 1, "R8");
    check("R8", win_flag, 1'b1, "clear loses to match");
    check("R7", win_evt, 1'b0, "event masked");
    cycle(0, 0, 0, 0, 1, 0, 2'd0, 1, 1, "R8");
    check("R8", win_flag, 1'b0, "clear");
    // R3: upper bits of upper threshold ignored, 0xFF05 is 5 at 8 bits.
    cycle(1, 'h006, 'h000, 'hFF05, 2, 0, 2'd0, 1, 0, "R3");
    check("R3", win_flag, 1'b0, "threshold high bits ignored");
    // R3: result bit 12 ignored at 12 bits; 0x1003 is 3 < 4.
    cycle(1, 'h1003, 'h000, 'h004, 2, 0, 2'd3, 1, 0, "R3");
    check("R3", win_flag, 1'b1, "result high bits ignored");
    cycle(0, 0, 0, 0, 0, 0, 2'd0, 0, 1, "R8");
    // R4: inside is strict at both bounds.
    cycle(1, 'h010, 'h010, 'h020, 3, 0, 2'd1, 1, 0, "R4");
    check("R4", win_flag, 1'b0, "inside at lower bound");
    cycle(1, 'h020, 'h010, 'h020, 4, 0, 2'd1, 1, 0, "R4");
    check("R4", win_flag, 1'b0, "outside at upper bound");
    // R2 at 10 bits: 0x200 is -512, below lower -1 (0x3FF).
    cycle(1, 'h200, 'h3FF, 'h000, 4, 1, 2'd1, 1, 0, "R2");
    check("R2", win_flag, 1'b1, "signed 10-bit outside");
    cycle(0, 0, 0, 0, 0, 0, 2'd0, 0, 1, "R8");
    // R6: off and unused modes stay quiet.
    cycle(1, 'h050, 'h000, 'h0FF, 0, 0, 2'd0, 1, 0, "R6");
    cycle(1, 'h050, 'h000, 'h0FF, 6, 0, 2'd0, 1, 0, "R6");
    check("R6", win_flag, 1'b0, "unused mode");
    // R5: matching result sets the flag one cycle later.
    cycle(1, 'h050, 'h000, 'h0FF, 3, 0, 2'd2, 1, 0, "R5");
    check("R5", win_evt, 1'b1, "event after inside hit");

    for (int i = 0; i < 3000; i++) begin
      cycle($urandom_range(0, 3) != 0, $urandom, $urandom, $urandom,
            $urandom_range(0, 7), $urandom_range(0, 1), 2'($urandom_range(0, 3)),
            $urandom_range(0, 1), $urandom_range(0, 5) == 0, "R4");
    end
    done = 1;
    summary();
  end
endmodule